// File: doc/BRIEF.md
# Byte-Wide BCD Calendar Register File

This block keeps a calendar (century, year, month, date, day of week, hours, minutes, seconds) in packed BCD. A host sees it as sixteen byte locations through a small asynchronous-style strobe interface. A prescaler counts pulses of a 32.768 kHz enable, which is synchronous to the system clock, and produces one seconds tick. On each tick the calendar counters step forward, and one cycle later their values are copied into a set of host-visible clock bytes. The host therefore reads a RAM-like image, not the live counters.

A control byte gives the host two freeze bits. The read-freeze bit stops the image from refreshing, so a multi-byte read is coherent. The counters keep running while it is set, so no seconds are lost. The write-freeze bit also stops the refresh. While it is set, the host edits the image. Clearing the bit transfers the whole image into the counters in a single cycle. The low six control bits hold a calibration value that is stored but does not act on timekeeping. Locations that are neither clock bytes nor the control byte are plain storage bytes.

Top module: `bcd_calendar_regs`

## Requirements
- R1: The address space has 16 byte locations selected by a 4-bit address. Locations 0h and 2h to 7h are plain storage that reads back the last byte written there.
- R2: Bus decode. With ce_n high there is no access. With ce_n low and we_n low, the byte is written on the clock edge whatever oe_n is. With ce_n low, oe_n low and we_n high, bus_oe is 1 and bus_rdata carries the addressed byte. In every other case bus_oe is 0 and bus_rdata is 00h.
- R3: One seconds tick occurs for every PRESCALE cycles in which osc_en is high. The count restarts from zero at reset.
- R4: The clock bytes are packed BCD at these addresses: Fh year (00-99), Eh month (01-12), Dh date, Ch day of week (1-7), Bh hours (00-23), Ah minutes, 9h seconds, 1h century. Reset gives century 20, year 00, month 01, date 01, day 1, 00:00:00 and control 00h.
- R5: A tick advances seconds. A seconds carry from 59 advances minutes, and a minutes carry from 59 advances hours. An hours carry from 23 advances both the date and the day of week, and the day of week wraps from 7 to 1.
- R6: April, June, September and November end after date 30. The other months, except February, end after date 31. Each month then rolls to date 01 of the next month, and December rolls to January of the next year.
- R7: February has 29 days when the year is a leap year, and 28 days otherwise. A year is a leap year when the binary year value is divisible by 4, except that year 00 is a leap year only when the century value is divisible by 4.
- R8: Year 99 rolls to 00 and increments the century byte.
- R9: Control bit 6 (read freeze) stops the clock bytes from refreshing while the counters keep counting. After the bit is cleared, the next refresh shows the full elapsed time.
- R10: Control bit 7 (write freeze) stops the refresh. Writing the control byte with bit 7 cleared while the bit is set loads all clock bytes into the counters. Counting then resumes from the loaded values.
- R11: Control bits 5:0 (calibration) read back as written and do not change the timekeeping.
- R12: With both freeze bits clear, the clock bytes are refreshed from the counters only after a tick. Clearing read freeze does not by itself change the clock bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| bus_rdata | output | 8 | Read data (00h when not reading) |
| bus_oe | output | 1 | High while a read cycle drives data |

## Verification
The assertions check the following on every cycle:
- the prescaler count stays in range and restarts after each tick;
- the counters change only on a tick or a load;
- the seconds, hours, day of week and date stay inside their BCD ranges, with the date limit depending on the month and leap-year state;
- the clock bytes stay unchanged while either freeze bit is set.

Only the bench scenarios can show the following:
- the calendar arithmetic at month, leap-year and century boundaries;
- that no time is lost across a read freeze;
- the transfer of an edited image on release of write freeze;
- the bus decode cases.

// File: rtl/cal_pkg.sv
// Package: shared time record and BCD calendar helpers.
// Assumes every field holds valid packed BCD.
package cal_pkg;

    typedef struct packed {
        logic [7:0] century;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
    } cal_time_t;

    typedef struct packed {
        logic       wr_frz;
        logic       rd_frz;
        logic [5:0] cal;
    } cal_ctrl_t;

    localparam cal_time_t TIME_RESET = '{
        century: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
        day: 8'h01, hour: 8'h00, minute: 8'h00, second: 8'h00
    };

    // Address map of the host-visible bytes
    localparam logic [3:0] A_CENT = 4'h1;
    localparam logic [3:0] A_CTRL = 4'h8;
    localparam logic [3:0] A_SEC  = 4'h9;
    localparam logic [3:0] A_MIN  = 4'hA;
    localparam logic [3:0] A_HOUR = 4'hB;
    localparam logic [3:0] A_DAY  = 4'hC;
    localparam logic [3:0] A_DATE = 4'hD;
    localparam logic [3:0] A_MON  = 4'hE;
    localparam logic [3:0] A_YEAR = 4'hF;

    // Convert a packed BCD byte (00-99) to binary
    function automatic logic [6:0] bcd2bin(input logic [7:0] v);
        return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
    endfunction

    // Add one to a packed BCD byte without range wrap
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap rule: year divisible by 4, year 00 only when century divisible by 4
    function automatic logic leap_year(input logic [7:0] cent, input logic [7:0] yr);
        logic [6:0] yb;
        logic [6:0] cb;
        yb = bcd2bin(yr);
        cb = bcd2bin(cent);
        if (yb[1:0] != 2'd0)
            return 1'b0;
        if (yb != 7'd0)
            return 1'b1;
        return (cb[1:0] == 2'd0);
    endfunction

    // Last date of a month, as packed BCD
    function automatic logic [7:0] month_end(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Module: divides the oscillator enable down to a one-cycle seconds tick.
// Assumes osc_en is synchronous to clk and at most one cycle wide per period.
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    output logic sec_tick
);
    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt;

    // Tick when the last oscillator pulse of a second arrives
    assign sec_tick = osc_en && (cnt == LAST);

    // Count oscillator pulses, wrapping at the end of each second
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (osc_en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_wrap_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> cnt == '0);
endmodule

// File: rtl/cal_counter.sv
// Module: live BCD calendar counters with a parallel load.
// Assumes loaded values are valid BCD inside the calendar ranges.
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  logic      load,
    input  cal_time_t load_val,
    output cal_time_t now
);
    cal_time_t nxt;
    logic      leap;
    logic [7:0] last_date;
    logic      c_sec, c_min, c_hour, c_date, c_mon, c_year;

    assign leap      = leap_year(now.century, now.year);
    assign last_date = month_end(now.month, leap);

    // Carry chain: each field rolls when it is at its top and the lower field carries
    assign c_sec  = (now.second >= 8'h59);
    assign c_min  = c_sec  && (now.minute >= 8'h59);
    assign c_hour = c_min  && (now.hour   >= 8'h23);
    assign c_date = c_hour && (now.date   >= last_date);
    assign c_mon  = c_date && (now.month  >= 8'h12);
    assign c_year = c_mon  && (now.year   >= 8'h99);

    // Compute the calendar one second ahead
    always_comb begin
        nxt        = now;
        nxt.second = c_sec ? 8'h00 : bcd_inc(now.second);
        if (c_sec)
            nxt.minute = c_min ? 8'h00 : bcd_inc(now.minute);
        if (c_min)
            nxt.hour = c_hour ? 8'h00 : bcd_inc(now.hour);
        if (c_hour) begin
            nxt.date = c_date ? 8'h01 : bcd_inc(now.date);
            nxt.day  = (now.day >= 8'h07) ? 8'h01 : bcd_inc(now.day);
        end
        if (c_date)
            nxt.month = c_mon ? 8'h01 : bcd_inc(now.month);
        if (c_mon)
            nxt.year = c_year ? 8'h00 : bcd_inc(now.year);
        if (c_year)
            nxt.century = (now.century >= 8'h99) ? 8'h00 : bcd_inc(now.century);
    end

    // Hold the counters; a load takes priority over a tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= TIME_RESET;
        else if (load)
            now <= load_val;
        else if (sec_tick)
            now <= nxt;
    end

    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick && !load |=> $stable(now));
    p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        now.second <= 8'h59 && now.second[3:0] <= 4'd9);
    p_hour_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        now.hour <= 8'h23);
    p_day_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        now.day >= 8'h01 && now.day <= 8'h07);
    p_date_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        now.date >= 8'h01 && now.date <= month_end(now.month, leap_year(now.century, now.year)));
    p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick && !load && c_year |=> now.year == 8'h00);
endmodule

// File: rtl/cal_regfile.sv
// Module: host-side register file: bus decode, control byte, storage bytes
// and the once-per-second image of the calendar counters.
// Assumes the strobes are synchronous to clk; a write takes effect on the edge.
module cal_regfile
    import cal_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  cal_time_t         now,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_oe,
    output logic              load,
    output cal_time_t         image
);
    localparam int DEPTH = 1 << ADDR_W;

    cal_ctrl_t         ctrl;
    logic [DATA_W-1:0] store [DEPTH];
    logic              wr_cyc;
    logic              rd_cyc;
    logic              tick_d;
    logic              frozen;
    logic              clk_byte_wr;

    // Decode the strobes: write wins over read when both are low
    assign wr_cyc = !ce_n && !we_n;
    assign rd_cyc = !ce_n && !oe_n && we_n;
    assign frozen = ctrl.wr_frz || ctrl.rd_frz;

    // Flag a host write that lands on one of the clock bytes
    always_comb begin
        case (bus_addr)
            A_CENT, A_SEC, A_MIN, A_HOUR, A_DAY, A_DATE, A_MON, A_YEAR:
                clk_byte_wr = wr_cyc;
            default:
                clk_byte_wr = 1'b0;
        endcase
    end

    // Transfer request when write freeze is released by the host
    assign load = wr_cyc && (bus_addr == A_CTRL) && ctrl.wr_frz && !bus_wdata[7];

    // Delay the tick so the image copies the counters after they step
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_d <= 1'b0;
        else
            tick_d <= sec_tick;
    end

    // Control byte: freeze bits and calibration value
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_cyc && bus_addr == A_CTRL)
            ctrl <= cal_ctrl_t'(bus_wdata);
    end

    // Plain storage bytes, one per address
    for (genvar g = 0; g < DEPTH; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= '0;
            else if (wr_cyc && bus_addr == ADDR_W'(g))
                store[g] <= bus_wdata;
        end
    end

    // Clock byte image: refreshed after a tick unless frozen; host writes edit it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            image <= TIME_RESET;
        end else begin
            if (tick_d && !frozen)
                image <= now;
            if (wr_cyc) begin
                case (bus_addr)
                    A_CENT: image.century <= bus_wdata;
                    A_YEAR: image.year    <= bus_wdata;
                    A_MON:  image.month   <= bus_wdata;
                    A_DATE: image.date    <= bus_wdata;
                    A_DAY:  image.day     <= bus_wdata;
                    A_HOUR: image.hour    <= bus_wdata;
                    A_MIN:  image.minute  <= bus_wdata;
                    A_SEC:  image.second  <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; drives zero outside a read cycle
    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            case (bus_addr)
                A_CENT:  bus_rdata = image.century;
                A_YEAR:  bus_rdata = image.year;
                A_MON:   bus_rdata = image.month;
                A_DATE:  bus_rdata = image.date;
                A_DAY:   bus_rdata = image.day;
                A_HOUR:  bus_rdata = image.hour;
                A_MIN:   bus_rdata = image.minute;
                A_SEC:   bus_rdata = image.second;
                A_CTRL:  bus_rdata = ctrl;
                default: bus_rdata = store[bus_addr];
            endcase
        end
    end
    assign bus_oe = rd_cyc;

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frozen && !clk_byte_wr |=> $stable(image));
    p_release_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ctrl.wr_frz);
    p_no_write_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(ctrl));
    p_refresh_only_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_d && !clk_byte_wr |=> $stable(image));
endmodule

// File: rtl/bcd_calendar_regs.sv
// Module: top of the BCD calendar register file.
// Joins the prescaler, the live counters and the host register file.
// Assumes osc_en pulses at the oscillator rate, synchronous to clk.
module bcd_calendar_regs
    import cal_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    output logic [7:0] bus_rdata,
    output logic       bus_oe
);
    logic      sec_tick;
    logic      load;
    cal_time_t now;
    cal_time_t image;

    cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .sec_tick (sec_tick)
    );

    cal_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load     (load),
        .load_val (image),
        .now      (now)
    );

    cal_regfile #(.ADDR_W(4), .DATA_W(8)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .now       (now),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .bus_rdata (bus_rdata),
        .bus_oe    (bus_oe),
        .load      (load),
        .image     (image)
    );
endmodule

// File: tb/sim_bcd_calendar_regs.sv
// Bench: directed scenarios, one task each, every task checks its own results.
module sim_bcd_calendar_regs;
    localparam int PS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       we_n = 1'b1;
    logic [7:0] bus_rdata;
    logic       bus_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_calendar_regs #(.PRESCALE(PS)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .bus_rdata(bus_rdata), .bus_oe(bus_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic bus_cycle(input logic ce, input logic oe, input logic we,
                             input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = ce; oe_n = oe; we_n = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_cycle(1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        checks++;
        if (bus_oe !== 1'b1) begin
            errors++;
            $display("FAIL R2 bus_oe got %b exp 1", bus_oe);
        end
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic expect_byte(input string tag, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    task automatic seconds(input int n);
        @(negedge clk);
        osc_en = 1'b1;
        repeat (n * PS) @(negedge clk);
        osc_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                            input logic [7:0] dt, input logic [7:0] dy, input logic [7:0] h,
                            input logic [7:0] mi, input logic [7:0] s);
        wr(4'h8, 8'h80);
        wr(4'h1, c);  wr(4'hF, y);  wr(4'hE, mo); wr(4'hD, dt);
        wr(4'hC, dy); wr(4'hB, h);  wr(4'hA, mi); wr(4'h9, s);
        wr(4'h8, 8'h00);
    endtask

    task automatic expect_date(input string tag, input logic [7:0] c, input logic [7:0] y,
                               input logic [7:0] mo, input logic [7:0] dt);
        expect_byte({tag, " century"}, 4'h1, c);
        expect_byte({tag, " year"},    4'hF, y);
        expect_byte({tag, " month"},   4'hE, mo);
        expect_byte({tag, " date"},    4'hD, dt);
    endtask

    task automatic expect_clock(input string tag, input logic [7:0] h,
                                input logic [7:0] mi, input logic [7:0] s);
        expect_byte({tag, " hour"}, 4'hB, h);
        expect_byte({tag, " min"},  4'hA, mi);
        expect_byte({tag, " sec"},  4'h9, s);
    endtask

    task automatic t_reset();
        expect_date("R4 reset", 8'h20, 8'h00, 8'h01, 8'h01);
        expect_byte("R4 reset day", 4'hC, 8'h01);
        expect_clock("R4 reset", 8'h00, 8'h00, 8'h00);
        expect_byte("R4 reset ctrl", 4'h8, 8'h00);
    endtask

    task automatic t_prescale();
        // R3: PS-1 pulses give no tick, the PS-th pulse gives exactly one
        @(negedge clk); osc_en = 1'b1;
        repeat (PS - 1) @(negedge clk);
        osc_en = 1'b0; repeat (3) @(negedge clk);
        expect_byte("R3 no early tick", 4'h9, 8'h00);
        @(negedge clk); osc_en = 1'b1;
        @(negedge clk); osc_en = 1'b0; repeat (3) @(negedge clk);
        expect_byte("R3 R12 one tick", 4'h9, 8'h01);
        seconds(5);
        expect_byte("R3 five ticks", 4'h9, 8'h06);
    endtask

    task automatic t_time_carry();
        set_time(8'h20, 8'h24, 8'h06, 8'h10, 8'h03, 8'h12, 8'h34, 8'h59);
        seconds(1);
        expect_clock("R5 min carry", 8'h12, 8'h35, 8'h00);
        set_time(8'h20, 8'h24, 8'h06, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_clock("R5 day carry", 8'h00, 8'h00, 8'h00);
        expect_byte("R5 date step", 4'hD, 8'h11);
        expect_byte("R5 weekday wrap", 4'hC, 8'h01);
    endtask

    task automatic t_months();
        set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R6 30-day", 8'h20, 8'h24, 8'h05, 8'h01);
        set_time(8'h20, 8'h24, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R6 31-day", 8'h20, 8'h24, 8'h05, 8'h31);
        set_time(8'h20, 8'h24, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R6 new year", 8'h20, 8'h25, 8'h01, 8'h01);
    endtask

    task automatic t_leap();
        set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R7 2000 feb28", 8'h20, 8'h00, 8'h02, 8'h29);
        seconds(86400 / 86400 * 0 + 0);
        set_time(8'h20, 8'h00, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R7 2000 feb29", 8'h20, 8'h00, 8'h03, 8'h01);
        set_time(8'h19, 8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R7 1900", 8'h19, 8'h00, 8'h03, 8'h01);
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R7 2023", 8'h20, 8'h23, 8'h03, 8'h01);
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R7 2024", 8'h20, 8'h24, 8'h02, 8'h29);
    endtask

    task automatic t_century();
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        seconds(1);
        expect_date("R8 century", 8'h21, 8'h00, 8'h01, 8'h01);
        expect_byte("R8 weekday", 4'hC, 8'h01);
    endtask

    task automatic t_read_freeze();
        set_time(8'h20, 8'h24, 8'h06, 8'h10, 8'h03, 8'h10, 8'h00, 8'h00);
        wr(4'h8, 8'h40);
        expect_byte("R9 ctrl", 4'h8, 8'h40);
        seconds(3);
        expect_byte("R9 frozen", 4'h9, 8'h00);
        wr(4'h8, 8'h00);
        expect_byte("R12 release no refresh", 4'h9, 8'h00);
        seconds(1);
        expect_byte("R9 no loss", 4'h9, 8'h04);
    endtask

    task automatic t_write_freeze();
        wr(4'h8, 8'h80);
        wr(4'h9, 8'h30);
        seconds(2);
        expect_byte("R10 frozen edit", 4'h9, 8'h30);
        expect_byte("R10 minute kept", 4'hA, 8'h00);
        wr(4'h8, 8'h00);
        seconds(1);
        expect_clock("R10 loaded", 8'h10, 8'h00, 8'h31);
    endtask

    task automatic t_calibration();
        wr(4'h8, 8'h15);
        expect_byte("R11 cal readback", 4'h8, 8'h15);
        seconds(1);
        expect_byte("R11 cal no effect", 4'h9, 8'h32);
        wr(4'h8, 8'h00);
    endtask

    task automatic t_bus();
        wr(4'h3, 8'hA5);
        wr(4'h0, 8'h5A);
        wr(4'h7, 8'h3C);
        expect_byte("R1 store 3", 4'h3, 8'hA5);
        expect_byte("R1 store 0", 4'h0, 8'h5A);
        expect_byte("R1 store 7", 4'h7, 8'h3C);
        bus_cycle(1'b1, 1'b1, 1'b0, 4'h3, 8'h11);
        expect_byte("R2 deselect write ignored", 4'h3, 8'hA5);
        bus_cycle(1'b0, 1'b0, 1'b0, 4'h3, 8'h22);
        expect_byte("R2 write wins over oe", 4'h3, 8'h22);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; bus_addr = 4'h3;
        #1;
        check("R2 no oe rdata", bus_rdata, 8'h00);
        check("R2 no oe flag", {7'd0, bus_oe}, 8'h00);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        #1;
        check("R2 deselect rdata", bus_rdata, 8'h00);
        check("R2 deselect flag", {7'd0, bus_oe}, 8'h00);
        @(negedge clk);
        oe_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_prescale();
        t_time_carry();
        t_months();
        t_leap();
        t_century();
        t_read_freeze();
        t_write_freeze();
        t_calibration();
        t_bus();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule